// File: doc/BRIEF.md
# Run-Length Sample Expander

The expander turns a byte stream of run-length-coded capture records back into a flat stream of wide samples. Each record is four bytes long: three bytes carry the levels of three channel groups, and the fourth holds a repeat value. The block takes the bytes one at a time on a valid/ready input. When a record is complete, it emits the same packed sample (repeat + 1) times on a valid/ready output. The top byte lane of each sample is always zero, because the fourth channel group is absent from the record.

A start pulse arms the block with an output budget, which is the largest number of samples it may produce in this session. A run longer than the budget that remains is cut short. Once the budget is used up, expansion ends and further input is refused. A session can also end early: an end-of-stream flag given with the repeat byte closes the session after that record has been fully emitted. The number of samples written so far is always visible at a port.

Top module: `rlx_expander`

## Requirements
- R1: Record bytes arrive in the order group A, group B, group C, repeat. Each emitted sample is {8'h00, C, B, A}, with A in bits 7:0, B in bits 15:8, C in bits 23:16, and bits 31:24 zero.
- R2: A record with repeat value r produces exactly r+1 samples (1 to 256) when the budget allows, and nothing more.
- R3: When r+1 exceeds the remaining budget, the run is clamped to the remaining budget.
- R4: When the remaining budget reaches zero, done_o rises, and both in_ready_o and out_valid_o stay low. Input offered in this state is ignored.
- R5: written_o counts accepted output samples, rising by exactly one per output transfer.
- R6: in_ready_o is high only while a record is being gathered, and it is low throughout the emission of a run. in_ready_o and out_valid_o are never high together.
- R7: While out_valid_o is high and out_ready_i is low, the sample is held unchanged. The run and the written count advance only on an accepted transfer.
- R8: If in_last_i is high with the repeat byte of a record, done_o rises once that record's last sample has been accepted.
- R9: A start_i pulse loads the budget, clears written_o and discards any partially gathered record. With a budget of zero, done_o is high in the next cycle.
- R10: After reset, in_ready_o, out_valid_o and done_o are low and written_o is zero until the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse; loads the budget |
| budget_i | input | CNT_W | Output sample budget captured on start |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_data_i | input | GRP_W | Record byte |
| in_last_i | input | 1 | End of stream, sampled with the repeat byte |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Sink accepts the sample |
| out_data_o | output | (NUM_GRP+1)*GRP_W | Packed sample, top lane zero |
| done_o | output | 1 | Session finished |
| written_o | output | CNT_W | Samples emitted this session |

## Verification
The bench builds the block with its defaults: 8-bit groups, three groups per record and a 16-bit budget. With an 8-bit repeat field, the full 256-sample run is reachable. The 16-bit budget is wide enough for a session to hold several maximal runs, and small enough that clamping can be forced with short budgets such as 1 or 20. The sink stalls on every third cycle, so holding and stepping under back-pressure are exercised during every run.

// File: rtl/rlx_pkg.sv
`timescale 1ns/1ps
package rlx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_EMIT   = 2'd2,
    ST_DONE   = 2'd3
  } rlx_state_e;
endpackage

// File: rtl/rlx_rec_gather.sv
`timescale 1ns/1ps
// Collects the group bytes of one record; flags the repeat byte.
module rlx_rec_gather #(
  parameter int GRP_W   = 8,
  parameter int NUM_GRP = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     take_i,
  input  logic [GRP_W-1:0]         byte_i,
  input  logic                     eos_i,
  output logic [NUM_GRP*GRP_W-1:0] grp_o,
  output logic                     rec_end_o,
  output logic                     eos_q_o
);
  localparam int IDX_W = $clog2(NUM_GRP + 1);
  localparam logic [IDX_W-1:0] REP_SLOT = IDX_W'(NUM_GRP);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             eos_q, eos_d;

  assign rec_end_o = take_i && (idx_q == REP_SLOT);

  always_comb begin
    idx_d = idx_q;
    if (clr_i) begin
      idx_d = '0;
    end else if (take_i) begin
      idx_d = (idx_q == REP_SLOT) ? '0 : idx_q + 1'b1;
    end
  end

  always_comb begin
    eos_d = eos_q;
    if (clr_i) begin
      eos_d = 1'b0;
    end else if (rec_end_o) begin
      eos_d = eos_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      eos_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      eos_q <= eos_d;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    logic             slot_en;
    logic [GRP_W-1:0] slot_q;
    assign slot_en = take_i && !clr_i && (idx_q == SLOT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= byte_i;
      end
    end
    assign grp_o[g*GRP_W +: GRP_W] = slot_q;
  end

  assign eos_q_o = eos_q;
endmodule

// File: rtl/rlx_run_ctr.sv
`timescale 1ns/1ps
// Run length, remaining budget and written count.
module rlx_run_ctr #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_budget_i,
  input  logic [CNT_W-1:0] budget_i,
  input  logic             load_rec_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             fire_i,
  output logic [CNT_W-1:0] written_o,
  output logic             last_rep_o,
  output logic             budget_last_o
);
  localparam int RUN_W = REP_W + 1;
  localparam int CMP_W = (CNT_W > RUN_W) ? CNT_W : RUN_W;

  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] written_q, written_d;
  logic [RUN_W-1:0] reps_q, reps_d;
  logic [RUN_W-1:0] run_len;
  logic             clamp;

  assign run_len = {1'b0, rep_i} + 1'b1;
  assign clamp   = CMP_W'(run_len) > CMP_W'(remain_q);

  always_comb begin
    remain_d  = remain_q;
    written_d = written_q;
    reps_d    = reps_q;
    if (load_budget_i) begin
      remain_d  = budget_i;
      written_d = '0;
      reps_d    = '0;
    end else if (load_rec_i) begin
      reps_d = clamp ? RUN_W'(remain_q) : run_len;
    end else if (fire_i) begin
      reps_d    = reps_q - 1'b1;
      remain_d  = remain_q - 1'b1;
      written_d = written_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q  <= '0;
      written_q <= '0;
      reps_q    <= '0;
    end else begin
      remain_q  <= remain_d;
      written_q <= written_d;
      reps_q    <= reps_d;
    end
  end

  assign written_o     = written_q;
  assign last_rep_o    = (reps_q == RUN_W'(1));
  assign budget_last_o = (remain_q == CNT_W'(1));
endmodule

// File: rtl/rlx_seq_fsm.sv
`timescale 1ns/1ps
// Session sequencer: gather a record, emit its run, finish.
module rlx_seq_fsm
  import rlx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic budget_zero_i,
  input  logic rec_end_i,
  input  logic fire_i,
  input  logic last_rep_i,
  input  logic budget_last_i,
  input  logic eos_i,
  output logic gather_o,
  output logic emit_o,
  output logic done_o
);
  rlx_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = budget_zero_i ? ST_DONE : ST_GATHER;
    end else begin
      case (st_q)
        ST_GATHER: if (rec_end_i) st_d = ST_EMIT;
        ST_EMIT: begin
          if (fire_i && last_rep_i) begin
            st_d = (budget_last_i || eos_i) ? ST_DONE : ST_GATHER;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign gather_o = (st_q == ST_GATHER);
  assign emit_o   = (st_q == ST_EMIT);
  assign done_o   = (st_q == ST_DONE);
endmodule

// File: rtl/rlx_expander.sv
`timescale 1ns/1ps
// Run-length sample expander top.
module rlx_expander #(
  parameter int CNT_W   = 16,
  parameter int GRP_W   = 8,
  parameter int NUM_GRP = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [CNT_W-1:0]             budget_i,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic [GRP_W-1:0]             in_data_i,
  input  logic                         in_last_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [(NUM_GRP+1)*GRP_W-1:0] out_data_o,
  output logic                         done_o,
  output logic [CNT_W-1:0]             written_o
);
  localparam int PAY_W = NUM_GRP * GRP_W;

  logic             gather, emit, take, fire, rec_end, eos_q;
  logic             last_rep, budget_last;
  logic [PAY_W-1:0] grp;

  assign take = in_valid_i && gather;
  assign fire = emit && out_ready_i;

  rlx_rec_gather #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start_i),
    .take_i    (take),
    .byte_i    (in_data_i),
    .eos_i     (in_last_i),
    .grp_o     (grp),
    .rec_end_o (rec_end),
    .eos_q_o   (eos_q)
  );

  rlx_run_ctr #(.CNT_W(CNT_W), .REP_W(GRP_W)) u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_budget_i (start_i),
    .budget_i      (budget_i),
    .load_rec_i    (rec_end),
    .rep_i         (in_data_i),
    .fire_i        (fire),
    .written_o     (written_o),
    .last_rep_o    (last_rep),
    .budget_last_o (budget_last)
  );

  rlx_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .budget_zero_i (budget_i == '0),
    .rec_end_i     (rec_end),
    .fire_i        (fire),
    .last_rep_i    (last_rep),
    .budget_last_i (budget_last),
    .eos_i         (eos_q),
    .gather_o      (gather),
    .emit_o        (emit),
    .done_o        (done_o)
  );

  assign in_ready_o  = gather;
  assign out_valid_o = emit;
  assign out_data_o  = {{GRP_W{1'b0}}, grp};
endmodule

// File: rtl/rlx_expander_chk.sv
`timescale 1ns/1ps
module rlx_expander_chk #(
  parameter int CNT_W   = 16,
  parameter int GRP_W   = 8,
  parameter int NUM_GRP = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_i,
  input logic [CNT_W-1:0]             budget_i,
  input logic                         in_ready_o,
  input logic                         out_valid_o,
  input logic                         out_ready_i,
  input logic [(NUM_GRP+1)*GRP_W-1:0] out_data_o,
  input logic                         done_o,
  input logic [CNT_W-1:0]             written_o
);
  localparam int OUT_W = (NUM_GRP + 1) * GRP_W;

  // R1
  top_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_data_o[OUT_W-1 -: GRP_W] == '0));

  // R6
  no_dual_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready_o && out_valid_o));

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!in_ready_o && !out_valid_o));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !start_i) |=> (written_o == $past(written_o) + 1'b1));

  // R7
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(out_valid_o && out_ready_i) && !start_i) |=> $stable(written_o));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (written_o == '0));

  // R9
  zero_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (budget_i == '0)) |=> done_o);
endmodule

bind rlx_expander rlx_expander_chk #(
  .CNT_W(CNT_W), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .budget_i    (budget_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .done_o      (done_o),
  .written_o   (written_o)
);

// File: tb/rlx_expander_tb.sv
`timescale 1ns/1ps
module rlx_expander_tb;
  localparam int CNT_W = 16;
  localparam int GRP_W = 8;
  localparam int NUM_GRP = 3;
  localparam int OUT_W = (NUM_GRP + 1) * GRP_W;

  // {budget (0 = continue session), last, repeat, C, B, A}
  localparam int NV = 6;
  localparam logic [48:0] VEC [NV] = '{
    {16'd20,   1'b0, 8'd2,   8'h33, 8'h22, 8'h11},
    {16'd0,    1'b0, 8'd0,   8'h66, 8'h55, 8'h44},
    {16'd0,    1'b0, 8'd4,   8'hC3, 8'hB2, 8'hA1},
    {16'd0,    1'b0, 8'd255, 8'h09, 8'h08, 8'h07},
    {16'd1000, 1'b0, 8'd255, 8'hAA, 8'h0F, 8'hF0},
    {16'd0,    1'b1, 8'd1,   8'h03, 8'h02, 8'h01}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] budget_i = '0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [GRP_W-1:0] in_data_i = '0;
  logic             in_last_i = 1'b0;
  logic             out_valid_o;
  logic             out_ready_i = 1'b0;
  logic [OUT_W-1:0] out_data_o;
  logic             done_o;
  logic [CNT_W-1:0] written_o;

  int checks = 0;
  int errors = 0;
  int stall_ctr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rlx_expander #(.CNT_W(CNT_W), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .budget_i(budget_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_last_i(in_last_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .done_o(done_o), .written_o(written_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [CNT_W-1:0] b);
    @(negedge clk);
    start_i = 1'b1;
    budget_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last);
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i = b;
    in_last_i = last;
    while (!in_ready_o) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid_i = 1'b0;
    in_last_i = 1'b0;
  endtask

  task automatic send_rec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                          input logic [7:0] rep, input logic last);
    send_byte(a, 1'b0);
    send_byte(b, 1'b0);
    send_byte(c, 1'b0);
    send_byte(rep, last);
  endtask

  // Consume n samples with a sink that stalls every third cycle.
  task automatic recv(input int n, input logic [OUT_W-1:0] exp);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      stall_ctr++;
      out_ready_i = (stall_ctr % 3) != 2;
      if (out_valid_o && out_ready_i) begin
        // R1 packing and R7 held data
        chk("R1 sample", {32'd0, out_data_o}, {32'd0, exp});
        if (got == 0) chk("R6 ready low in run", {63'd0, in_ready_o}, 64'd0);
        @(posedge clk);
        #1;
        got++;
      end
    end
    out_ready_i = 1'b0;
    @(negedge clk);
    // R2 no extra sample after the run
    chk("R2 run end", {63'd0, out_valid_o}, 64'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int remain = 0;
    int total = 0;
    logic [OUT_W-1:0] held;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 ready", {63'd0, in_ready_o}, 64'd0);
    chk("R10 valid", {63'd0, out_valid_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 done", {63'd0, done_o}, 64'd0);
    chk("R10 written", {48'd0, written_o}, 64'd0);
    chk("R10 idle ready", {63'd0, in_ready_o}, 64'd0);

    // Vector walk: R1 R2 R3 R5 R8
    for (int i = 0; i < NV; i++) begin
      logic [15:0] vb;
      logic        vl;
      logic [7:0]  vr, vc, vbb, va;
      int n;
      {vb, vl, vr, vc, vbb, va} = VEC[i];
      if (vb != 0) begin
        do_start(vb);
        remain = vb;
        total = 0;
        chk("R9 written cleared", {48'd0, written_o}, 64'd0);
      end
      send_rec(va, vbb, vc, vr, vl);
      n = int'(vr) + 1;
      if (n > remain) n = remain;          // R3 clamp
      recv(n, {8'h00, vc, vbb, va});
      remain -= n;
      total += n;
      chk("R5 written", {48'd0, written_o}, 64'(total));
      if (remain == 0 || vl) begin
        chk("R4 R8 done", {63'd0, done_o}, 64'd1);
        chk("R4 ready low", {63'd0, in_ready_o}, 64'd0);
      end else begin
        chk("R8 not done", {63'd0, done_o}, 64'd0);
        chk("R6 gathering", {63'd0, in_ready_o}, 64'd1);
      end
    end

    // R4 input ignored after done
    @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i = 8'h5A;
    repeat (6) @(negedge clk);
    chk("R4 ignored ready", {63'd0, in_ready_o}, 64'd0);
    chk("R4 ignored valid", {63'd0, out_valid_o}, 64'd0);
    chk("R4 ignored written", {48'd0, written_o}, 64'd258);
    in_valid_i = 1'b0;

    // R9 partial record discarded by a new start
    do_start(16'd5);
    send_byte(8'hDE, 1'b0);
    send_byte(8'hAD, 1'b0);
    do_start(16'd5);
    chk("R9 restart written", {48'd0, written_o}, 64'd0);
    send_rec(8'h31, 8'h32, 8'h33, 8'd0, 1'b0);
    recv(1, 32'h00333231);
    chk("R9 after restart done", {63'd0, done_o}, 64'd0);

    // R7 stall holds sample and count
    send_rec(8'h44, 8'h45, 8'h46, 8'd1, 1'b0);
    @(negedge clk);
    held = out_data_o;
    repeat (3) @(negedge clk);
    chk("R7 valid held", {63'd0, out_valid_o}, 64'd1);
    chk("R7 data held", {32'd0, out_data_o}, {32'd0, held});
    chk("R7 count held", {48'd0, written_o}, 64'd1);
    recv(2, 32'h00464544);
    chk("R7 count after", {48'd0, written_o}, 64'd3);

    // R9 zero budget: done at once
    do_start(16'd0);
    chk("R9 zero done", {63'd0, done_o}, 64'd1);
    chk("R9 zero written", {48'd0, written_o}, 64'd0);
    chk("R4 zero ready", {63'd0, in_ready_o}, 64'd0);

    // R3 budget of one against a maximal run
    do_start(16'd1);
    send_rec(8'h0A, 8'h0B, 8'h0C, 8'd255, 1'b0);
    recv(1, 32'h000C0B0A);
    chk("R3 single written", {48'd0, written_o}, 64'd1);
    chk("R3 single done", {63'd0, done_o}, 64'd1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule